// File: doc/BRIEF.md
# FIFO Serial Receiver with Line Status

This block receives asynchronous serial characters and turns them into bytes that a processor reads through a small register window. It samples the line on a 16x oversampling enable, accepts characters of 5 to 8 data bits, and can check a parity bit. It stores each character in a 16-entry receive queue together with that character's parity, framing and break flags. It keeps a sticky overrun flag. It raises one interrupt output, with the interrupt's cause reported through a priority-encoded identification register.

Software programs the character format through the line-format register. It enables the queue, flushes it and picks the interrupt trigger depth through the queue-control register. When the queue is off, the receiver holds one character and behaves as a single holding register. When the queue is on, a character timeout reports data that sits below the trigger depth after the stream stops. The register window has four addresses. Address 0 reads and removes the oldest character. Address 1 reads the identification register and writes queue control. Address 2 reads and writes the line format. Address 3 reads line status.

Top module: `serial_rx_fifo`

## Requirements
- R1: A falling edge starts a character only if the line is still low on the 8th oversample; a low pulse shorter than half a bit time stores nothing and leaves line status at 0x00.
- R2: The line-format field [1:0] selects 5+n data bits, which are received least significant bit first; a read of address 0 returns the oldest character right-aligned with its unused upper bits zero and removes it.
- R3: Line-format bit 3 enables a parity bit after the last data bit. With bit 5 clear, bit 4 set expects even parity and bit 4 clear expects odd parity. With bit 5 set, the expected parity bit is 1 when bit 4 is 0 and 0 when bit 4 is 1. A mismatch sets line-status bit 2 for that character.
- R4: A low level at the centre of the stop bit sets line-status bit 3 for that character, and the character is still stored.
- R5: A character whose data bits, parity bit and stop bit are all low sets line-status bit 4 (and bit 3). Exactly one zero character is stored, and the receiver waits for the line to go high before it starts another character.
- R6: When a character completes while the store is full (1 entry with the queue off, 16 with it on), line-status bit 1 is set and the stored characters are kept unchanged. A read of line status clears bit 1.
- R7: A write to address 1 sets queue enable (bit 0) and trigger depth (bits 7:6: 00=1, 01=4, 10=8, 11=14). Setting bit 1, or changing the enable, empties the queue.
- R8: The identification register reads 0x_6 for a line-status condition (highest priority), 0x_4 for data available, 0x_C for a character timeout and 0x_1 for none. Bits 7:6 read 11 with the queue on and 00 with it off. The irq output is high exactly when a cause is pending. A line-status cause is pending from an errored or overrunning character until line status is read.
- R9: Data available is pending when the stored count reaches the trigger depth with the queue on, or when at least one character is held with the queue off.
- R10: With the queue on and not empty, a character timeout becomes pending after 4 character times (frame bits × 16 oversamples) with no character received and no read of address 0. A read of address 0 clears it.
- R11: Line-status bit 0 shows that at least one character is stored. Bit 7 shows, with the queue on, that some stored character carries a parity, framing or break flag, and reads 0 with the queue off. Bits 2–4 describe the oldest stored character.
- R12: After reset the identification register reads 0x01, line status reads 0x00, the line format reads 0x03 (8 data bits, no parity) and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strike; a read of address 0 or 3 has side effects |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request, high while any cause is pending |

## Verification
A stored character becomes visible in line status a few cycles after the centre of its stop bit: two synchronizer stages, the sampling register and the queue write. The bench therefore drives each frame to the end of its stop bit, then leaves one idle bit time (32 clocks) before any read. Register reads are combinational, so the bench samples them in the cycle it strobes and never right after a clock edge. The character timeout is due 1280 clocks after the last stored character at the tested format. The bench checks the identification register once well before that point and once well after it, so a timeout that fires early and one that fires late are both caught.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
    localparam int OS_RATE = 16;

    localparam logic [1:0] ADDR_RBR = 2'd0;
    localparam logic [1:0] ADDR_IIR = 2'd1;
    localparam logic [1:0] ADDR_LCR = 2'd2;
    localparam logic [1:0] ADDR_LSR = 2'd3;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_cfg_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_t;

    typedef enum logic [3:0] {
        IID_NONE = 4'b0001,
        IID_LINE = 4'b0110,
        IID_DATA = 4'b0100,
        IID_TMO  = 4'b1100
    } iid_t;

    // start + data + optional parity + one or two stop bits
    function automatic logic [3:0] frame_bits(line_cfg_t c);
        return 4'd7 + {2'b00, c.wlen} + {3'b000, c.par_en} + {3'b000, c.two_stop};
    endfunction

    function automatic logic [4:0] trig_count(logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic want_parity(logic stick, logic even, logic data_xor);
        if (stick) return !even;
        return even ? data_xor : !data_xor;
    endfunction
endpackage

// File: rtl/srx_sampler.sv
`timescale 1ns/1ps
module srx_sampler
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       even,
    input  logic       stick,
    output logic       char_valid,
    output rx_char_t   char_out
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] MID_LAST = CW'(OS_RATE / 2 - 2);
    localparam logic [CW-1:0] BIT_LAST = CW'(OS_RATE - 1);

    logic [1:0]    sync_q;
    logic          rx_s;
    rx_state_t     state_q;
    logic [CW-1:0] tick_q;
    logic [2:0]    bit_q;
    logic [7:0]    shift_q;
    logic          par_q;
    logic [7:0]    aligned;
    logic [2:0]    last_bit;
    logic          bit_end;

    assign rx_s = sync_q[1];

    always_comb begin
        last_bit = 3'd4 + {1'b0, wlen};
        aligned  = shift_q >> (3'd3 - {1'b0, wlen});
        bit_end  = os_tick && (tick_q == BIT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= 2'b11;
            state_q    <= RX_IDLE;
            tick_q     <= '0;
            bit_q      <= '0;
            shift_q    <= '0;
            par_q      <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            sync_q     <= {sync_q[0], rxd};
            char_valid <= 1'b0;
            case (state_q)
                RX_IDLE: if (os_tick && !rx_s) begin
                    state_q <= RX_START;
                    tick_q  <= '0;
                end
                RX_START: if (os_tick) begin
                    if (tick_q == MID_LAST) begin
                        tick_q  <= '0;
                        bit_q   <= '0;
                        state_q <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                RX_DATA: if (bit_end) begin
                    tick_q  <= '0;
                    shift_q <= {rx_s, shift_q[7:1]};
                    if (bit_q == last_bit) state_q <= par_en ? RX_PAR : RX_STOP;
                    else                   bit_q   <= bit_q + 1'b1;
                end else if (os_tick) begin
                    tick_q <= tick_q + 1'b1;
                end
                RX_PAR: if (bit_end) begin
                    tick_q  <= '0;
                    par_q   <= rx_s;
                    state_q <= RX_STOP;
                end else if (os_tick) begin
                    tick_q <= tick_q + 1'b1;
                end
                RX_STOP: if (bit_end) begin
                    tick_q        <= '0;
                    char_valid    <= 1'b1;
                    char_out.data <= aligned;
                    char_out.perr <= par_en && (par_q != want_parity(stick, even, ^aligned));
                    char_out.ferr <= !rx_s;
                    char_out.brk  <= !rx_s && (aligned == 8'h00) && !(par_en && par_q);
                    state_q       <= rx_s ? RX_IDLE : RX_HOLD;
                end else if (os_tick) begin
                    tick_q <= tick_q + 1'b1;
                end
                RX_HOLD: if (rx_s) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_store.sv
`timescale 1ns/1ps
module srx_store
    import srx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fifo_mode,
    input  logic             push,
    input  rx_char_t         push_data,
    input  logic             pop,
    output rx_char_t         head,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic             any_err
);
    localparam int PTR_W = $clog2(DEPTH);

    rx_char_t         mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q, cap;
    logic             full, do_push, do_pop;

    always_comb begin
        cap      = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
        full     = cnt_q >= cap;
        do_push  = push && !full;
        do_pop   = pop && (cnt_q != '0);
        overflow = push && full;
        head     = mem_q[rd_q];
        count    = cnt_q;
    end

    always_comb begin
        any_err = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(PTR_W'(PTR_W'(i) - rd_q)) < cnt_q)
                any_err = any_err | mem_q[i].perr | mem_q[i].ferr | mem_q[i].brk;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/srx_timeout.sv
`timescale 1ns/1ps
module srx_timeout #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             armed,
    input  logic             restart,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] tmr_q;

    assign expired = armed && (tmr_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !armed || restart) tmr_q <= '0;
        else if (os_tick && tmr_q < limit) tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/serial_rx_fifo.sv
`timescale 1ns/1ps
module serial_rx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] reg_addr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TMR_W = $clog2(TMO_CHARS * 12 * OS_RATE + 1);

    logic [5:0]       lcr_q;
    logic             fifo_en_q;
    logic [1:0]       trig_q;
    logic             oe_q, ls_pend_q;
    line_cfg_t        cfg;
    logic             char_valid;
    rx_char_t         char_new, head;
    logic [CNT_W-1:0] fifo_count;
    logic             overflow, any_err, tmo_hit, has_data;
    logic             rd_rbr, rd_lsr, wr_fcr, wr_lcr, flush, data_avail;
    logic [TMR_W-1:0] tmo_limit;
    logic [7:0]       lsr;
    iid_t             iid;

    assign cfg = line_cfg_t'(lcr_q);

    always_comb begin
        rd_rbr   = reg_rd && (reg_addr == ADDR_RBR);
        rd_lsr   = reg_rd && (reg_addr == ADDR_LSR);
        wr_fcr   = reg_wr && (reg_addr == ADDR_IIR);
        wr_lcr   = reg_wr && (reg_addr == ADDR_LCR);
        flush    = wr_fcr && (reg_wdata[1] || (reg_wdata[0] != fifo_en_q));
        has_data = fifo_count != '0;
        tmo_limit = TMR_W'(TMO_CHARS) * TMR_W'(frame_bits(cfg)) * TMR_W'(OS_RATE);
    end

    srx_sampler u_sampler (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .wlen(cfg.wlen), .par_en(cfg.par_en), .even(cfg.even), .stick(cfg.stick),
        .char_valid(char_valid), .char_out(char_new)
    );

    srx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .fifo_mode(fifo_en_q),
        .push(char_valid), .push_data(char_new), .pop(rd_rbr),
        .head(head), .count(fifo_count), .overflow(overflow), .any_err(any_err)
    );

    srx_timeout #(.TMR_W(TMR_W)) u_timeout (
        .clk(clk), .rst(rst), .os_tick(os_tick),
        .armed(fifo_en_q && has_data), .restart(char_valid || rd_rbr),
        .limit(tmo_limit), .expired(tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q     <= 6'h03;
            fifo_en_q <= 1'b0;
            trig_q    <= 2'd0;
            oe_q      <= 1'b0;
            ls_pend_q <= 1'b0;
        end else begin
            if (wr_lcr) lcr_q <= reg_wdata[5:0];
            if (wr_fcr) begin
                fifo_en_q <= reg_wdata[0];
                trig_q    <= reg_wdata[7:6];
            end
            if (overflow)    oe_q <= 1'b1;
            else if (rd_lsr) oe_q <= 1'b0;
            if (overflow || (char_valid && (char_new.perr || char_new.ferr || char_new.brk)))
                ls_pend_q <= 1'b1;
            else if (rd_lsr)
                ls_pend_q <= 1'b0;
        end
    end

    always_comb begin
        data_avail = fifo_en_q ? (fifo_count >= CNT_W'(trig_count(trig_q))) : has_data;
        if (ls_pend_q)       iid = IID_LINE;
        else if (data_avail) iid = IID_DATA;
        else if (tmo_hit)    iid = IID_TMO;
        else                 iid = IID_NONE;
        irq = (iid != IID_NONE);
        lsr = {fifo_en_q && any_err, 2'b00,
               has_data && head.brk, has_data && head.ferr, has_data && head.perr,
               oe_q, has_data};
        case (reg_addr)
            ADDR_RBR: reg_rdata = has_data ? head.data : 8'h00;
            ADDR_IIR: reg_rdata = {{2{fifo_en_q}}, 2'b00, iid};
            ADDR_LCR: reg_rdata = {2'b00, lcr_q};
            default:  reg_rdata = lsr;
        endcase
    end
endmodule

// File: rtl/serial_rx_fifo_chk.sv
`timescale 1ns/1ps
module serial_rx_fifo_chk
    import srx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       reg_addr,
    input logic             reg_rd,
    input logic [7:0]       reg_rdata,
    input logic             irq,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_en
);
    AST_FIFO_ID: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_IIR && fifo_en) |-> reg_rdata[7:6] == 2'b11); // R8
    AST_LEGACY_ID: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_IIR && !fifo_en) |-> reg_rdata[7:6] == 2'b00); // R8
    AST_IRQ_IID: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_IIR) |-> (irq == !reg_rdata[0])); // R8
    AST_READY_BIT: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_LSR) |-> (reg_rdata[0] == (fifo_count != '0))); // R11
    AST_LSR7_LEGACY: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_LSR && !fifo_en) |-> !reg_rdata[7]); // R11
    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> fifo_count <= CNT_W'(1)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH)); // R6
    AST_POP_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_RBR && fifo_count != '0) |=> fifo_count <= $past(fifo_count)); // R2
endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq(irq), .fifo_count(fifo_count), .fifo_en(fifo_en_q)
);

// File: tb/serial_rx_fifo_tb.sv
`timescale 1ns/1ps
module serial_rx_fifo_tb_top;
    localparam int BIT_CLK = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic [7:0] got;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) os_tick <= ~os_tick;

    serial_rx_fifo dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic par_for(input logic [7:0] d, input int wl, input logic even, input logic stick);
        logic [7:0] m;
        m = 8'hFF >> (8 - wl);
        if (stick) return !even;
        return even ? ^(d & m) : !(^(d & m));
    endfunction

    task automatic send_frame(input logic [7:0] d, input int wl, input logic pen,
                              input logic pbit, input logic stopv);
        hold(1'b0, BIT_CLK);
        for (int i = 0; i < wl; i++) hold(d[i], BIT_CLK);
        if (pen) hold(pbit, BIT_CLK);
        hold(stopv, BIT_CLK);
        hold(1'b1, BIT_CLK);
    endtask

    task automatic send_ok(input logic [7:0] d, input logic [7:0] lcr);
        int wl;
        wl = 5 + int'(lcr[1:0]);
        send_frame(d, wl, lcr[3], par_for(d, wl, lcr[4], lcr[5]), 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R12 reset state
        rd_reg(2'd1, got); check("R12 iid", got, 8'h01);
        rd_reg(2'd3, got); check("R12 lsr", got, 8'h00);
        rd_reg(2'd2, got); check("R12 lcr", got, 8'h03);
        check("R12 irq", {7'b0, irq}, 8'h00);

        // R2/R3 sweep: word lengths x parity modes x values (holding-register mode)
        for (int wsel = 0; wsel < 4; wsel++) begin
            for (int mode = 0; mode < 5; mode++) begin
                logic [7:0] lcr, mask;
                int wl;
                wl   = 5 + wsel;
                mask = 8'hFF >> (8 - wl);
                case (mode)
                    0: lcr = 8'(wsel);
                    1: lcr = 8'(wsel) | 8'h08;
                    2: lcr = 8'(wsel) | 8'h18;
                    3: lcr = 8'(wsel) | 8'h28;
                    default: lcr = 8'(wsel) | 8'h38;
                endcase
                wr_reg(2'd2, lcr);
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] v;
                    v = (k == 0) ? 8'h00 : 8'((k * 91 + wsel * 17 + mode * 29) & 255);
                    send_ok(v, lcr);
                    rd_reg(2'd3, got); check("R3 lsr clean", got, 8'h01);
                    rd_reg(2'd0, got); check("R2 data", got, v & mask);
                end
                if (mode != 0) begin
                    logic [7:0] v;
                    v = 8'h5A & mask;
                    send_frame(v, wl, 1'b1, !par_for(v, wl, lcr[4], lcr[5]), 1'b1);
                    rd_reg(2'd3, got); check("R3 parity error", got, 8'h05);
                    rd_reg(2'd0, got); check("R3 data kept", got, v);
                end
            end
        end
        wr_reg(2'd2, 8'h03);

        // R4 framing error
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0);
        rd_reg(2'd3, got); check("R4 lsr", got, 8'h09);
        rd_reg(2'd0, got); check("R4 data", got, 8'h55);

        // R5 break: line low for many bit times
        hold(1'b0, 20 * BIT_CLK);
        hold(1'b1, 2 * BIT_CLK);
        rd_reg(2'd1, got); check("R5 iid line", got, 8'h06);
        rd_reg(2'd3, got); check("R5 lsr", got, 8'h19);
        rd_reg(2'd0, got); check("R5 data", got, 8'h00);
        rd_reg(2'd3, got); check("R5 single entry", got, 8'h00);

        // R1 false start
        hold(1'b0, 12);
        hold(1'b1, 24 * BIT_CLK);
        rd_reg(2'd3, got); check("R1 glitch ignored", got, 8'h00);

        // R6 overrun, holding-register mode
        send_ok(8'h41, 8'h03);
        send_ok(8'h42, 8'h03);
        rd_reg(2'd1, got); check("R8 iid line", got, 8'h06);
        check("R8 irq", {7'b0, irq}, 8'h01);
        rd_reg(2'd3, got); check("R6 lsr oe", got, 8'h03);
        rd_reg(2'd1, got); check("R9 iid data", got, 8'h04);
        rd_reg(2'd0, got); check("R6 first kept", got, 8'h41);
        rd_reg(2'd3, got); check("R6 oe cleared", got, 8'h00);
        rd_reg(2'd1, got); check("R8 iid none", got, 8'h01);

        // R7/R9 trigger depths
        for (int t = 0; t < 4; t++) begin
            int lvl;
            lvl = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
            wr_reg(2'd1, 8'((t << 6) | 3));
            for (int j = 0; j < lvl - 1; j++) send_ok(8'(j + 48), 8'h03);
            rd_reg(2'd1, got); check("R9 below trigger", got, 8'hC1);
            send_ok(8'h7E, 8'h03);
            rd_reg(2'd1, got); check("R9 at trigger", got, 8'hC4);
            check("R9 irq", {7'b0, irq}, 8'h01);
            wr_reg(2'd1, 8'((t << 6) | 3));
            rd_reg(2'd3, got); check("R7 flushed", got, 8'h00);
        end

        // R6 overrun with 16-entry queue
        wr_reg(2'd1, 8'hC3);
        for (int i = 0; i < 17; i++) send_ok(8'((i * 37 + 5) & 255), 8'h03);
        rd_reg(2'd3, got); check("R6 queue oe", got, 8'h03);
        for (int i = 0; i < 16; i++) begin
            rd_reg(2'd0, got); check("R6 queue data", got, 8'((i * 37 + 5) & 255));
        end
        rd_reg(2'd3, got); check("R6 17th dropped", got, 8'h00);

        // R7 flush bit
        send_ok(8'h11, 8'h03);
        send_ok(8'h22, 8'h03);
        wr_reg(2'd1, 8'hC3);
        rd_reg(2'd3, got); check("R7 clear", got, 8'h00);
        rd_reg(2'd1, got); check("R7 iid after clear", got, 8'hC1);

        // R8/R11 priority and error-in-queue bit
        wr_reg(2'd1, 8'h03);
        wr_reg(2'd2, 8'h1B);
        send_frame(8'h01, 8, 1'b1, 1'b0, 1'b1);
        rd_reg(2'd1, got); check("R8 line first", got, 8'hC6);
        rd_reg(2'd3, got); check("R11 lsr err", got, 8'h85);
        rd_reg(2'd1, got); check("R8 then data", got, 8'hC4);
        rd_reg(2'd0, got); check("R3 data", got, 8'h01);
        rd_reg(2'd3, got); check("R11 lsr empty", got, 8'h00);
        wr_reg(2'd2, 8'h03);

        // R10 character timeout (8N1: 4 x 10 x 16 ticks = 1280 clocks)
        wr_reg(2'd1, 8'h83);
        send_ok(8'h5A, 8'h03);
        send_ok(8'h6B, 8'h03);
        repeat (1000) @(negedge clk);
        rd_reg(2'd1, got); check("R10 not yet", got, 8'hC1);
        repeat (400) @(negedge clk);
        rd_reg(2'd1, got); check("R10 timeout", got, 8'hCC);
        check("R10 irq", {7'b0, irq}, 8'h01);
        rd_reg(2'd0, got); check("R10 data", got, 8'h5A);
        rd_reg(2'd1, got); check("R10 cleared", got, 8'hC1);
        rd_reg(2'd0, got); check("R10 data2", got, 8'h6B);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule